// File: doc/BRIEF.md
# Multi-Pipe Interrupt Aggregator

This block gathers interrupt events from a set of DMA pipes and from the controller, and reduces them to one level interrupt line for each execution environment. Each pipe keeps a small sticky status word. The word is qualified by a per-pipe enable, and the result becomes one bit of a 32-bit source word. Bit 31 of that word carries the controller's own qualified status: timer, empty, error and bus-response error.

Each execution environment has its own mask over the source word. The environment can read back its masked source word and uses it to find the pipes to service. Software clears status by writing ones to a clear register. Writing back the value it read clears exactly the bits it has seen. The pipe datapaths are outside the block and appear only as single-cycle event pulses.

All registers are 32 bits wide and use byte addresses. Reads are combinational from `addr`. Writes take effect at the rising clock edge while `wr_en` is high.

Top module: `pipe_irq_aggregator`

## Requirements
- R1: The register at address 0x000 reads NPIPE in bits [7:0] and NENV in bits [15:8]. All other bits read as zero.
- R2: A pulse on the event input of pipe p, bit b, sets bit b of that pipe's status register at 0x1000+p*0x10 on the next clock edge, whatever the pipe's enable holds. The bit meanings are 0 processed descriptor, 1 timer, 2 wake, 3 out of descriptors, 4 error, 5 transfer end.
- R3: Writing to a pipe's clear register at 0x1000+p*0x10+0x8 clears each status bit written as 1 and leaves the bits written as 0. With no event and no clear, a status bit holds its value.
- R4: An event and a clear that hit the same status bit in the same cycle leave that bit set.
- R5: Pipe p's source bit (bit p) is the OR of its status AND its enable register at 0x1000+p*0x10+0x4. The enable register uses the same bit positions as the status register.
- R6: An environment's source word at 0x400+e*0x80 shows a pipe's source bit only if the matching bit of that environment's mask register at 0x400+e*0x80+0x4 is set.
- R7: The global status register at 0x004 uses bit 4 for timer, bit 3 for empty, bit 2 for error and bit 1 for bus response error. These bits latch from the `g_evt` pulses. The global enable register at 0x008 and the write-1-to-clear register at 0x00C use the same bit positions. Bit 31 of the source word is the OR of global status AND global enable, and it is gated by mask bit 31.
- R8: `irq[e]` is a level that equals the OR of environment e's masked source word. It stays high across idle cycles until the contributing status is cleared or masked.
- R9: The mask of one environment has no effect on the source word or the interrupt line of another environment.
- R10: Writes to read-only, unmapped or out-of-range addresses change no state. Reads of unmapped or out-of-range addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pipe_evt | input | NPIPE*6 | Event pulses; bits [6p+5:6p] belong to pipe p |
| g_evt | input | 4 | Controller events; index 4 timer, 3 empty, 2 error, 1 bus error |
| irq | output | NENV | Level interrupt line for each environment |

## Verification
The bench builds the block with NPIPE=5 and NENV=3. With five pipes, the out-of-range pipe index 5 can be reached within the pipe address window. With three environments, the bench can show an interrupt on one line while the other two stay quiet under different masks. The small parameter values also keep the identification word short enough to check as a single literal. The directed scenarios cover a disabled status bit latching silently, a clear that collides with an event, a partial clear, and the global route through bit 31.

// File: rtl/pipe_irq_aggregator.sv
module pipe_irq_aggregator #(
  parameter int NPIPE = 31,
  parameter int NENV  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [15:0]          addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NPIPE*6-1:0]   pipe_evt,
  input  logic [4:1]           g_evt,
  output logic [NENV-1:0]      irq
);
  localparam int PW = 6;
  localparam logic [31:0] MASK_OK = {1'b1, 31'((64'd1 << NPIPE) - 1)};

  logic [NPIPE*PW-1:0] pst_f, pen_f;
  logic [NPIPE*32-1:0] prd_f;
  logic [NENV*32-1:0]  erd_f;
  logic [30:0]         pipe_word;
  logic [4:1]          gstat, gen;
  logic                gsrc;

  wire       in_pipe = addr[15:12] == 4'h1;
  wire [7:0] pidx    = addr[11:4];
  wire [1:0] preg    = addr[3:2];
  wire       in_env  = addr[15:10] == 6'b000001 && addr[6:3] == 4'h0;
  wire [2:0] eidx    = addr[9:7];
  wire       gsel_en = wr_en && addr == 16'h0008;
  wire       gsel_cl = wr_en && addr == 16'h000C;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstat <= '0;
      gen   <= '0;
    end else begin
      if (gsel_en) gen <= wdata[4:1];
      gstat <= (gstat & ~(gsel_cl ? wdata[4:1] : 4'h0)) | g_evt;
    end
  end
  assign gsrc = |(gstat & gen);

  for (genvar p = 0; p < 31; p++) begin : g_word
    if (p < NPIPE) begin : g_on
      assign pipe_word[p] = |(pst_f[p*PW +: PW] & pen_f[p*PW +: PW]);
    end else begin : g_off
      assign pipe_word[p] = 1'b0;
    end
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic [PW-1:0] st, en;
    wire sel = in_pipe && pidx == 8'(p);
    wire clr = wr_en && sel && preg == 2'd2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st <= '0;
        en <= '0;
      end else begin
        if (wr_en && sel && preg == 2'd1) en <= wdata[PW-1:0];
        st <= (st & ~(clr ? wdata[PW-1:0] : '0)) | pipe_evt[p*PW +: PW];
      end
    end
    assign pst_f[p*PW +: PW] = st;
    assign pen_f[p*PW +: PW] = en;
    assign prd_f[p*32 +: 32] = !sel ? 32'h0 :
                               preg == 2'd0 ? {26'h0, st} :
                               preg == 2'd1 ? {26'h0, en} : 32'h0;
  end

  for (genvar e = 0; e < NENV; e++) begin : g_env
    logic [31:0] msk;
    wire  [31:0] src = {gsrc, pipe_word} & msk;
    wire sel = in_env && eidx == 3'(e);
    always_ff @(posedge clk) begin
      if (!rst_n) msk <= '0;
      else if (wr_en && sel && addr[2]) msk <= wdata & MASK_OK;
    end
    assign irq[e] = |src;
    assign erd_f[e*32 +: 32] = !sel ? 32'h0 : (addr[2] ? msk : src);
  end

  always_comb begin
    rdata = 32'h0;
    case (addr)
      16'h0000: rdata = {16'h0, 8'(NENV), 8'(NPIPE)};
      16'h0004: rdata = {27'h0, gstat, 1'b0};
      16'h0008: rdata = {27'h0, gen, 1'b0};
      default: ;
    endcase
    for (int p = 0; p < NPIPE; p++) rdata = rdata | prd_f[p*32 +: 32];
    for (int e = 0; e < NENV; e++)  rdata = rdata | erd_f[e*32 +: 32];
  end
endmodule

module pipe_irq_aggregator_chk #(
  parameter int NPIPE = 31,
  parameter int NENV  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [NPIPE*6-1:0] pipe_evt,
  input logic [4:1]         g_evt,
  input logic [NENV-1:0]    irq,
  input logic [NPIPE*6-1:0] pst_f,
  input logic [4:1]         gstat
);
  for (genvar i = 0; i < NPIPE*6; i++) begin : g_bit
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_evt[i] |=> pst_f[i]);
  end

  for (genvar i = 1; i <= 4; i++) begin : g_glob
    assert_glob_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      g_evt[i] |=> gstat[i]);
  end

  assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && pipe_evt == '0) |=> $stable(pst_f));

  for (genvar e = 0; e < NENV; e++) begin : g_line
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[e]) |-> $past(wr_en || pipe_evt != '0 || g_evt != '0));
    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[e] |-> (pst_f != '0 || gstat != '0));
  end
endmodule

bind pipe_irq_aggregator pipe_irq_aggregator_chk #(.NPIPE(NPIPE), .NENV(NENV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pipe_evt(pipe_evt), .g_evt(g_evt),
  .irq(irq), .pst_f(pst_f), .gstat(gstat)
);

// File: tb/test_pipe_irq_aggregator.sv
module test_pipe_irq_aggregator;
  localparam int NP = 5;
  localparam int NE = 3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NP*6-1:0] pipe_evt = 0;
  logic [4:1] g_evt = 0;
  logic [NE-1:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pipe_irq_aggregator #(.NPIPE(NP), .NENV(NE)) i_pipe_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pipe_evt(pipe_evt), .g_evt(g_evt), .irq(irq));

  function automatic logic [15:0] pa(int p, int r); return 16'(32'h1000 + p*16 + r*4); endfunction
  function automatic logic [15:0] ea(int e, int r); return 16'(32'h400 + e*128 + r*4); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(int p, logic [5:0] b);
    @(negedge clk); pipe_evt[p*6 +: 6] = b;
    @(negedge clk); pipe_evt = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R8 reset irq", 32'(irq), 0);
    rd(16'h0000, d); chk("R1 id", d, 32'h0000_0305);
    rd(pa(0, 0), d); chk("R2 reset status", d, 0);
  endtask

  task automatic t_silent_latch;
    logic [31:0] d;
    pulse(1, 6'h04);
    rd(pa(1, 0), d); chk("R2 latch while disabled", d, 32'h4);
    chk("R5 no irq without enable", 32'(irq), 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(ea(0, 1), 32'h2);
    chk("R5 masked but disabled", 32'(irq), 0);
    wr(pa(1, 1), 32'h4);
    chk("R8 irq env0", 32'(irq), 32'h1);
    rd(ea(0, 0), d); chk("R6 src env0", d, 32'h2);
    rd(ea(1, 0), d); chk("R9 src env1 unmasked", d, 0);
    repeat (5) @(negedge clk);
    chk("R8 level holds", 32'(irq), 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(pa(1, 2), 32'h0);
    rd(pa(1, 0), d); chk("R3 zero write keeps", d, 32'h4);
    pulse(1, 6'h21);
    wr(pa(1, 2), 32'h4);
    rd(pa(1, 0), d); chk("R3 partial clear", d, 32'h21);
    chk("R8 irq drops", 32'(irq), 0);
    wr(pa(1, 2), 32'h21);
    rd(pa(1, 0), d); chk("R3 full clear", d, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    pulse(3, 6'h01);
    @(negedge clk); wr_en = 1; addr = pa(3, 2); wdata = 32'h1; pipe_evt[18] = 1'b1;
    @(negedge clk); wr_en = 0; pipe_evt = 0;
    rd(pa(3, 0), d); chk("R4 event beats clear", d, 32'h1);
    wr(pa(3, 2), 32'h1);
    rd(pa(3, 0), d); chk("R3 clear after collide", d, 0);
  endtask

  task automatic t_global;
    logic [31:0] d;
    @(negedge clk); g_evt = 4'b1000;
    @(negedge clk); g_evt = 0;
    rd(16'h0004, d); chk("R7 timer status bit4", d, 32'h10);
    wr(16'h0008, 32'h10);
    wr(ea(2, 1), 32'h8000_0000);
    chk("R7 irq env2 only", 32'(irq), 32'h4);
    rd(ea(2, 0), d); chk("R7 src bit31", d, 32'h8000_0000);
    wr(16'h000C, 32'h10);
    rd(16'h0004, d); chk("R7 global clear", d, 0);
    chk("R8 irq env2 drops", 32'(irq), 0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, d); chk("R10 id read-only", d, 32'h0000_0305);
    wr(pa(4, 0), 32'h3F);
    rd(pa(4, 0), d); chk("R10 status read-only", d, 0);
    rd(pa(5, 1), d); chk("R10 out of range pipe", d, 0);
    rd(16'h0200, d); chk("R10 unmapped", d, 0);
    wr(ea(1, 1), 32'h7FFF_FFFF);
    rd(ea(1, 1), d); chk("R10 mask keeps valid bits", d, 32'h1F);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_silent_latch();
    t_route();
    t_clear();
    t_collide();
    t_global();
    t_ignored();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule